// File: doc/BRIEF.md
# Sticky Thermal Status Log Register

This block holds a 32-bit package thermal status word for three thermal conditions: the thermal control circuit being active, the bidirectional processor-hot line being driven, and the critical temperature being crossed. Each condition has two bits in the word. One is a live copy of the condition's level, registered once. The other is a sticky log that latches on a rising edge of that level and stays set after the level drops.

The host reads the word by pulsing a request together with a 32-bit clear mask, which is active low. A zero in a log position clears that log. A one leaves it alone. A zero anywhere else makes the mask illegal: the read then returns a failing completion code and leaves every log as it was. The word returned always holds the logs as they were before the read's own clear took effect. Only a legal read or a reset can clear a log. If a new rising edge arrives in the same cycle as a clear of that log, the log stays set. How the request is carried to the block and how the thermal conditions are produced are both outside the block.

Top module: `thermal_status_log`

## Requirements
- R1: A rising edge on a condition input sets that condition's log bit. The log stays set after the input falls.
- R2: A log bit drops only on a legal read that clears it or on reset. A condition held high after its log was cleared does not set the log again.
- R3: A legal read whose mask has a 0 in a log position clears that log after the read.
- R4: A mask bit of 1 in a log position leaves that log unchanged.
- R5: A mask with a 0 at any position other than bits 1, 3 and 5 is illegal. The read returns completion code 0x90 and no log bit changes.
- R6: A legal read returns completion code 0x40.
- R7: Word layout: bit 2k holds the registered level of condition k and bit 2k+1 holds its log. k=0 is thermal control activity, k=1 is processor-hot and k=2 is critical temperature. Bits 31..6 read as zero.
- R8: The returned word shows the log values from before that read's clear.
- R9: If a rising edge and a clear of the same log happen in the same cycle, the log ends up set.
- R10: The response (valid, word, code) appears on the clock edge that samples the request and is valid for exactly one cycle.
- R11: Reset clears all log and status bits, and no response is issued while reset is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| therm_status_i | input | 3 | Live condition levels: bit 0 thermal control activity, bit 1 processor-hot, bit 2 critical temperature |
| rd_req_i | input | 1 | One-cycle read request |
| rd_mask_i | input | 32 | Active-low log clear mask sampled with the request |
| rd_valid_o | output | 1 | Response valid, one cycle per request |
| rd_word_o | output | 32 | Status word, with logs shown before the clear |
| rd_cc_o | output | 8 | Completion code: 0x40 for success, 0x90 for an illegal mask |

## Verification
The clear path is tested with four kinds of mask. An all-ones mask must change nothing. A mask with a single zero at a log position must clear one log and leave the others intact. A mask that clears all three logs shows whether a level that stays high comes back as a new event. Masks with zeros at a status position or at the top bit must be rejected as a whole, even when they also hold legal zeros. Condition patterns cover a single rise, a rise followed by a fall, and two conditions rising together, which tells a live level apart from a sticky log. A rise placed in the same cycle as a clear exposes the priority between setting and clearing. A reset applied while logs are set shows that reset is the only path other than a read that clears them.

// File: rtl/thermlog_pkg.sv
package thermlog_pkg;
  localparam int unsigned TL_WORD_W   = 32;
  localparam int unsigned TL_NUM_COND = 3;
  localparam int unsigned TL_CC_W     = 8;

  typedef logic [TL_CC_W-1:0] tl_ccode_t;

  localparam tl_ccode_t TL_CC_OK  = 8'h40;
  localparam tl_ccode_t TL_CC_BAD = 8'h90;
endpackage

// File: rtl/thl_rst_sync.sv
module thl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/thl_edge_det.sv
module thl_edge_det #(
  parameter int unsigned NUM_COND = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_COND-1:0] level_i,
  output logic [NUM_COND-1:0] level_q,
  output logic [NUM_COND-1:0] rise_o
);
  logic [NUM_COND-1:0] level_d;

  always_comb begin
    level_d = level_i;
    rise_o  = level_i & ~level_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_d;
  end
endmodule

// File: rtl/thl_mask_check.sv
module thl_mask_check #(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned NUM_COND = 3
) (
  input  logic [WORD_W-1:0]   mask_i,
  output logic [NUM_COND-1:0] clr_o,
  output logic                legal_o
);
  logic [WORD_W-1:0] legal_pos;

  for (genvar p = 0; p < WORD_W; p++) begin : g_pos
    if ((p % 2 == 1) && (p < 2 * NUM_COND)) begin : g_log
      assign legal_pos[p] = 1'b1;
    end else begin : g_other
      assign legal_pos[p] = 1'b0;
    end
  end

  for (genvar k = 0; k < NUM_COND; k++) begin : g_clr
    assign clr_o[k] = ~mask_i[2*k+1];
  end

  assign legal_o = ~|(~mask_i & ~legal_pos);
endmodule

// File: rtl/thl_log_bank.sv
module thl_log_bank #(
  parameter int unsigned NUM_COND = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_COND-1:0] set_i,
  input  logic [NUM_COND-1:0] clr_i,
  output logic [NUM_COND-1:0] log_q
);
  logic [NUM_COND-1:0] log_d;
  logic                log_en;

  always_comb begin
    log_d  = (log_q & ~clr_i) | set_i;
    log_en = |(set_i | clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      log_q <= '0;
    else if (log_en) log_q <= log_d;
  end
endmodule

// File: rtl/thermal_status_log.sv
module thermal_status_log
  import thermlog_pkg::*;
#(
  parameter int unsigned WORD_W   = TL_WORD_W,
  parameter int unsigned NUM_COND = TL_NUM_COND
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_COND-1:0] therm_status_i,
  input  logic                rd_req_i,
  input  logic [WORD_W-1:0]   rd_mask_i,
  output logic                rd_valid_o,
  output logic [WORD_W-1:0]   rd_word_o,
  output logic [TL_CC_W-1:0]  rd_cc_o
);
  logic                rst_sync_n;
  logic [NUM_COND-1:0] st_q;
  logic [NUM_COND-1:0] rise;
  logic [NUM_COND-1:0] clr_req;
  logic [NUM_COND-1:0] clr_en;
  logic                mask_legal;
  logic [NUM_COND-1:0] log_q;

  logic [WORD_W-1:0]   word_now;
  logic                rsp_valid_q, rsp_valid_d;
  logic [WORD_W-1:0]   rsp_word_q,  rsp_word_d;
  tl_ccode_t           rsp_cc_q,    rsp_cc_d;

  thl_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  thl_edge_det #(.NUM_COND(NUM_COND)) u_edge (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .level_i (therm_status_i),
    .level_q (st_q),
    .rise_o  (rise)
  );

  thl_mask_check #(.WORD_W(WORD_W), .NUM_COND(NUM_COND)) u_mask (
    .mask_i  (rd_mask_i),
    .clr_o   (clr_req),
    .legal_o (mask_legal)
  );

  assign clr_en = (rd_req_i && mask_legal) ? clr_req : '0;

  thl_log_bank #(.NUM_COND(NUM_COND)) u_logs (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (rise),
    .clr_i (clr_en),
    .log_q (log_q)
  );

  always_comb begin
    word_now = '0;
    for (int k = 0; k < int'(NUM_COND); k++) begin
      word_now[2*k]   = st_q[k];
      word_now[2*k+1] = log_q[k];
    end
  end

  always_comb begin
    rsp_valid_d = rd_req_i;
    rsp_word_d  = word_now;
    rsp_cc_d    = mask_legal ? TL_CC_OK : TL_CC_BAD;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rsp_valid_q <= 1'b0;
    else             rsp_valid_q <= rsp_valid_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_word_q <= '0;
      rsp_cc_q   <= TL_CC_OK;
    end else if (rd_req_i) begin
      rsp_word_q <= rsp_word_d;
      rsp_cc_q   <= rsp_cc_d;
    end
  end

  assign rd_valid_o = rsp_valid_q;
  assign rd_word_o  = rsp_word_q;
  assign rd_cc_o    = rsp_cc_q;
endmodule

// File: rtl/thermal_status_log_chk.sv
module thermal_status_log_chk
  import thermlog_pkg::*;
#(
  parameter int unsigned WORD_W   = TL_WORD_W,
  parameter int unsigned NUM_COND = TL_NUM_COND
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_COND-1:0] status_i,
  input logic                rd_req_i,
  input logic [WORD_W-1:0]   rd_mask_i,
  input logic                rd_valid_o,
  input logic [WORD_W-1:0]   rd_word_o,
  input logic [TL_CC_W-1:0]  rd_cc_o,
  input logic [NUM_COND-1:0] log_q
);
  localparam logic [WORD_W-1:0] USED_BITS = {WORD_W{1'b1}} >> (WORD_W - 2 * NUM_COND);

  logic [NUM_COND-1:0] seen_q;
  logic [NUM_COND-1:0] rise_c;
  logic [WORD_W-1:0]   ok_zero;
  logic                bad_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= status_i;
  end

  always_comb begin
    rise_c  = status_i & ~seen_q;
    ok_zero = '0;
    for (int k = 0; k < int'(NUM_COND); k++) ok_zero[2*k+1] = 1'b1;
    bad_mask = |(~rd_mask_i & ~ok_zero);
  end

  AST_LOG_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_c) |=> ((log_q & $past(rise_c)) == $past(rise_c))); // R1

  AST_LOG_HOLD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req_i |=> ((~log_q & $past(log_q)) == '0)); // R2

  AST_BAD_MASK_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && bad_mask && (rise_c == '0)) |=> (log_q == $past(log_q))); // R5

  AST_BAD_MASK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && bad_mask) |=> (rd_cc_o == TL_CC_BAD)); // R5

  AST_GOOD_MASK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && !bad_mask) |=> (rd_cc_o == TL_CC_OK)); // R6

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> ((rd_word_o & ~USED_BITS) == '0)); // R7

  AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_i |=> rd_valid_o); // R10

  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req_i |=> !rd_valid_o); // R10
endmodule

bind thermal_status_log thermal_status_log_chk #(
  .WORD_W   (WORD_W),
  .NUM_COND (NUM_COND)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .status_i   (therm_status_i),
  .rd_req_i   (rd_req_i),
  .rd_mask_i  (rd_mask_i),
  .rd_valid_o (rd_valid_o),
  .rd_word_o  (rd_word_o),
  .rd_cc_o    (rd_cc_o),
  .log_q      (log_q)
);

// File: tb/thermal_status_log_tb.sv
`timescale 1ns/1ps
module thermal_status_log_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  therm_status_i;
  logic        rd_req_i;
  logic [31:0] rd_mask_i;
  logic        rd_valid_o;
  logic [31:0] rd_word_o;
  logic [7:0]  rd_cc_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  localparam logic [31:0] KEEP_ALL = 32'hFFFF_FFFF;

  always #2.5 clk = ~clk;

  thermal_status_log u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .therm_status_i (therm_status_i),
    .rd_req_i       (rd_req_i),
    .rd_mask_i      (rd_mask_i),
    .rd_valid_o     (rd_valid_o),
    .rd_word_o      (rd_word_o),
    .rd_cc_o        (rd_cc_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Request at a negedge; sample at the next negedge after the capturing edge.
  task automatic do_read(input logic [31:0] mask, input logic [2:0] st_new,
                         input bit set_st, output logic [31:0] w, output logic [7:0] cc);
    @(negedge clk);
    rd_req_i  = 1'b1;
    rd_mask_i = mask;
    if (set_st) therm_status_i = st_new;
    @(negedge clk);
    rd_req_i  = 1'b0;
    rd_mask_i = KEEP_ALL;
    check("R10 valid after request", {31'd0, rd_valid_o}, 32'd1);
    w  = rd_word_o;
    cc = rd_cc_o;
  endtask

  task automatic read(input logic [31:0] mask, output logic [31:0] w, output logic [7:0] cc);
    do_read(mask, 3'b000, 1'b0, w, cc);
  endtask

  task automatic t_reset();
    logic [31:0] w; logic [7:0] cc;
    rst_n = 1'b0; therm_status_i = '0; rd_req_i = 1'b0; rd_mask_i = KEEP_ALL;
    tick(3);
    check("R11 no response in reset", {31'd0, rd_valid_o}, 32'd0);
    rst_n = 1'b1;
    tick(4);
    read(KEEP_ALL, w, cc);
    check("R11 word zero after reset", w, 32'h0);
    check("R6 ok code", {24'd0, cc}, 32'h40);
    @(negedge clk);
    check("R10 valid lasts one cycle", {31'd0, rd_valid_o}, 32'd0);
  endtask

  task automatic t_rise();
    logic [31:0] w; logic [7:0] cc;
    therm_status_i = 3'b001; tick(2);
    read(KEEP_ALL, w, cc);
    check("R1 TCC log and status", w, 32'h3);
    therm_status_i = 3'b000; tick(2);
    read(KEEP_ALL, w, cc);
    check("R1 log sticky after fall", w, 32'h2);
    therm_status_i = 3'b110; tick(2);
    read(KEEP_ALL, w, cc);
    check("R7 layout two conditions", w, 32'h3E);
  endtask

  task automatic t_clear_one();
    logic [31:0] w; logic [7:0] cc;
    read(32'hFFFF_FFFD, w, cc);
    check("R8 pre-clear word", w, 32'h3E);
    check("R6 ok code on legal clear", {24'd0, cc}, 32'h40);
    read(KEEP_ALL, w, cc);
    check("R3 R4 only TCC log cleared", w, 32'h3C);
  endtask

  task automatic t_illegal();
    logic [31:0] w; logic [7:0] cc;
    read(32'hFFFF_FFD4, w, cc);
    check("R5 bad code status-bit zero", {24'd0, cc}, 32'h90);
    check("R5 word still returned", w, 32'h3C);
    read(32'h7FFF_FFF7, w, cc);
    check("R5 bad code top-bit zero", {24'd0, cc}, 32'h90);
    read(KEEP_ALL, w, cc);
    check("R5 logs unchanged", w, 32'h3C);
  endtask

  task automatic t_held_level();
    logic [31:0] w; logic [7:0] cc;
    read(32'hFFFF_FFD5, w, cc);
    check("R6 clear-all legal", {24'd0, cc}, 32'h40);
    tick(4);
    read(KEEP_ALL, w, cc);
    check("R2 held level does not re-log", w, 32'h14);
  endtask

  task automatic t_collide();
    logic [31:0] w; logic [7:0] cc;
    therm_status_i = 3'b001; tick(2);
    therm_status_i = 3'b000; tick(2);
    do_read(32'hFFFF_FFFD, 3'b001, 1'b1, w, cc);
    check("R9 pre-clear word in collision", w, 32'h2);
    read(KEEP_ALL, w, cc);
    check("R9 set wins over clear", w, 32'h3);
  endtask

  task automatic t_reset_clears();
    logic [31:0] w; logic [7:0] cc;
    therm_status_i = 3'b000; tick(2);
    rst_n = 1'b0; tick(2);
    rst_n = 1'b1; tick(4);
    read(KEEP_ALL, w, cc);
    check("R11 reset clears logs", w, 32'h0);
  endtask

  initial begin
    t_reset();
    t_rise();
    t_clear_one();
    t_illegal();
    t_held_level();
    t_collide();
    t_reset_clears();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule